// File: doc/BRIEF.md
# Context-Indexed Two-Level Address Translator

This block turns a 24-bit virtual address from a 68000-class bus into a 31-bit physical address through two map memories held on chip. A context register and the upper virtual address bits pick a segment number from the segment map. That segment number and four more address bits pick a page entry from the page map. The page entry carries a 20-bit physical page number and three protection bits. No table walk goes out to memory. The result, or a fault flag, comes back one clock after the request.

Both maps and the context registers are loaded by privileged software through control space (function code 3). After reset the block sits in boot mode. In boot mode, supervisor program fetches select the boot PROM directly and skip translation. Interrupt-acknowledge cycles always pass straight through.

Top module: `ctx_mmu`

## Requirements
- R1: Out of reset, `rsp_vld`, `fault` and `prom_sel` are low, both context registers read 0, and boot mode is on.
- R2: Every cycle with `req` high produces `rsp_vld` high in the next cycle. A cycle without `req` produces `rsp_vld` low in the next cycle.
- R3: A translated access uses the supervisor context when `fc[2]` is 1 (codes 5 and 6) and the user context otherwise. The segment map is read at `{ctx, va[23:15]}`. The page map is read at `{segment, va[14:11]}`. The result is `pa = {ppn, va[10:0]}`.
- R4: A page entry with its valid bit (bit 22) clear raises `fault`.
- R5: A user access (`fc[2]`=0) to a page whose supervisor-only bit (bit 21) is set raises `fault`. A supervisor access to the same page does not.
- R6: A write to a page whose writable bit (bit 20) is clear raises `fault`. A read of that page does not.
- R7: Function code 7 bypasses translation. It gives `pa` equal to the zero-extended `va` and never faults.
- R8: While boot mode is on, function code 6 asserts `prom_sel`, returns the zero-extended `va` and does not fault. Other codes still translate. Once boot mode is cleared, code 6 translates normally.
- R9: Control space is function code 3. `va[23:22]` selects the target: 0 selects the segment map, 1 the page map, 2 the supervisor context (with the boot bit at `wdata[3]` and the context at `wdata[2:0]`), and 3 the user context. `va[13:2]` is the map index. A page entry is written from `wdata[22:0]` as {valid, supervisor-only, writable, ppn[19:0]}. Writes occur only on control-space write cycles; a write with any other function code changes no map and no register.
- R10: A control-space read returns the selected map entry or register, zero-extended, on `rdata` with `rsp_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, address and function code valid |
| fc | input | 3 | Bus function code |
| wr | input | 1 | 1 for a write access |
| va | input | 24 | Virtual address |
| wdata | input | 32 | Write data for control-space writes |
| rsp_vld | output | 1 | Result valid, one clock after `req` |
| pa | output | 31 | Physical address |
| fault | output | 1 | Translation or permission fault |
| prom_sel | output | 1 | Boot PROM selected |
| rdata | output | 32 | Control-space read data |

## Verification
Four properties are checked on every cycle:
- the one-clock response timing;
- the fact that `prom_sel` and `fault` are never high together;
- the fault-free pass-through of interrupt-acknowledge cycles and the PROM selection for boot fetches;
- the fact that non-control writes leave the user context register unchanged.

Only the bench scenarios can show the rest:
- the composed physical address;
- which context a function code picks;
- the three fault causes, since each needs map contents loaded beforehand;
- read-back of the maps through control space.

// File: rtl/ctx_mmu_pkg.sv
// Shared widths, codes and the page-entry layout for the translator.
// Assumes the segment-map index width equals the page-map index width.
package ctx_mmu_pkg;
    localparam int VA_W      = 24;
    localparam int OFF_W     = 11;
    localparam int PGIDX_W   = 4;
    localparam int VSEG_W    = VA_W - OFF_W - PGIDX_W;   // 9
    localparam int CTX_W     = 3;
    localparam int SEG_W     = 8;
    localparam int PPN_W     = 20;
    localparam int PA_W      = PPN_W + OFF_W;            // 31
    localparam int DATA_W    = 32;
    localparam int MAP_AW    = CTX_W + VSEG_W;           // 12
    localparam int PTE_W     = PPN_W + 3;                // 23
    localparam int SEL_HI    = VA_W - 1;
    localparam int IDX_LO    = 2;

    typedef struct packed {
        logic             valid;
        logic             sup_only;
        logic             writable;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic [2:0] {
        FC_UDATA = 3'd1,
        FC_UPROG = 3'd2,
        FC_CTRL  = 3'd3,
        FC_SDATA = 3'd5,
        FC_SPROG = 3'd6,
        FC_IACK  = 3'd7
    } fc_e;

    typedef enum logic [1:0] {
        SEL_SEG  = 2'd0,
        SEL_PAGE = 2'd1,
        SEL_SCTX = 2'd2,
        SEL_UCTX = 2'd3
    } ctl_sel_e;
endpackage

// File: rtl/mmu_map_ram.sv
// Map memory: one synchronous write port and one combinational read port.
// Assumes the contents are loaded by software before use and not reset.
module mmu_map_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one entry on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Return the addressed entry in the same cycle.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/mmu_ctx_regs.sv
// Context registers and boot-mode flag.
// Assumes the write strobes are already qualified to control-space writes.
module mmu_ctx_regs
    import ctx_mmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_sup,
    input  logic             we_usr,
    input  logic [CTX_W:0]   wdata,
    output logic [CTX_W-1:0] sctx,
    output logic [CTX_W-1:0] uctx,
    output logic             boot_on
);
    // Hold the supervisor context and boot bit; boot mode starts on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sctx    <= '0;
            boot_on <= 1'b1;
        end else if (we_sup) begin
            sctx    <= wdata[CTX_W-1:0];
            boot_on <= wdata[CTX_W];
        end
    end

    // Hold the user context.
    always_ff @(posedge clk) begin
        if (!rst_n)      uctx <= '0;
        else if (we_usr) uctx <= wdata[CTX_W-1:0];
    end
endmodule

// File: rtl/mmu_perm_check.sv
// Protection check on a page entry against the access privilege and direction.
// Pure combinational; the caller decides whether the access is translated.
module mmu_perm_check
    import ctx_mmu_pkg::*;
(
    input  pte_t pte,
    input  logic is_super,
    input  logic is_write,
    output logic fault
);
    // Fault on a missing page, a privilege breach or a write to read-only.
    always_comb begin
        fault = !pte.valid
              || (pte.sup_only && !is_super)
              || (is_write && !pte.writable);
    end
endmodule

// File: rtl/ctx_mmu.sv
// Two-level translator top: context selection, segment map, page map,
// protection check, boot PROM bypass and control-space access.
// Assumes one request per cycle, with address and code held while req is high.
module ctx_mmu
    import ctx_mmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [2:0]        fc,
    input  logic              wr,
    input  logic [VA_W-1:0]   va,
    input  logic [DATA_W-1:0] wdata,
    output logic              rsp_vld,
    output logic [PA_W-1:0]   pa,
    output logic              fault,
    output logic              prom_sel,
    output logic [DATA_W-1:0] rdata
);
    logic              is_ctrl;
    logic [1:0]        ctl_sel;
    logic [MAP_AW-1:0] ctl_idx;
    logic [CTX_W-1:0]  sctx, uctx, ctx;
    logic              boot_on;
    logic [MAP_AW-1:0] seg_raddr, pg_raddr;
    logic [SEG_W-1:0]  seg_q;
    logic [PTE_W-1:0]  pte_raw;
    pte_t              pte;
    logic              perm_fault;
    logic [PA_W-1:0]   pa_d;
    logic              fault_d, prom_d;
    logic [DATA_W-1:0] rdata_d;
    logic [PA_W-1:0]   va_ext;

    // Decode control-space selector, index and the active context.
    always_comb begin
        is_ctrl = req && (fc == FC_CTRL);
        ctl_sel = va[SEL_HI -: 2];
        ctl_idx = va[IDX_LO +: MAP_AW];
        ctx     = fc[2] ? sctx : uctx;
        va_ext  = {{(PA_W-VA_W){1'b0}}, va};
    end

    mmu_ctx_regs ctx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_sup  (is_ctrl && wr && ctl_sel == SEL_SCTX),
        .we_usr  (is_ctrl && wr && ctl_sel == SEL_UCTX),
        .wdata   (wdata[CTX_W:0]),
        .sctx    (sctx),
        .uctx    (uctx),
        .boot_on (boot_on)
    );

    // Segment-map read address: control index or context plus segment bits.
    always_comb seg_raddr = is_ctrl ? ctl_idx : {ctx, va[VA_W-1 -: VSEG_W]};

    mmu_map_ram #(.AW(MAP_AW), .DW(SEG_W)) seg_map_i (
        .clk   (clk),
        .we    (is_ctrl && wr && ctl_sel == SEL_SEG),
        .waddr (ctl_idx),
        .wdata (wdata[SEG_W-1:0]),
        .raddr (seg_raddr),
        .rdata (seg_q)
    );

    // Page-map read address: control index or segment plus page bits.
    always_comb pg_raddr = is_ctrl ? ctl_idx : {seg_q, va[OFF_W +: PGIDX_W]};

    mmu_map_ram #(.AW(MAP_AW), .DW(PTE_W)) page_map_i (
        .clk   (clk),
        .we    (is_ctrl && wr && ctl_sel == SEL_PAGE),
        .waddr (ctl_idx),
        .wdata (wdata[PTE_W-1:0]),
        .raddr (pg_raddr),
        .rdata (pte_raw)
    );

    always_comb pte = pte_t'(pte_raw);

    mmu_perm_check perm_i (
        .pte      (pte),
        .is_super (fc[2]),
        .is_write (wr),
        .fault    (perm_fault)
    );

    // Choose the response for the access type.
    always_comb begin
        pa_d    = '0;
        fault_d = 1'b0;
        prom_d  = 1'b0;
        rdata_d = '0;
        if (fc == FC_IACK) begin
            pa_d = va_ext;
        end else if (fc == FC_CTRL) begin
            case (ctl_sel)
                SEL_SEG:  rdata_d = {{(DATA_W-SEG_W){1'b0}}, seg_q};
                SEL_PAGE: rdata_d = {{(DATA_W-PTE_W){1'b0}}, pte_raw};
                SEL_SCTX: rdata_d = {{(DATA_W-CTX_W-1){1'b0}}, boot_on, sctx};
                default:  rdata_d = {{(DATA_W-CTX_W){1'b0}}, uctx};
            endcase
        end else if (fc == FC_SPROG && boot_on) begin
            prom_d = 1'b1;
            pa_d   = va_ext;
        end else begin
            pa_d    = {pte.ppn, va[OFF_W-1:0]};
            fault_d = perm_fault;
        end
    end

    // Register the response one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            pa       <= '0;
            fault    <= 1'b0;
            prom_sel <= 1'b0;
            rdata    <= '0;
        end else begin
            rsp_vld  <= req;
            pa       <= req ? pa_d    : '0;
            fault    <= req && fault_d;
            prom_sel <= req && prom_d;
            rdata    <= req ? rdata_d : '0;
        end
    end
endmodule

// File: rtl/ctx_mmu_chk.sv
// Cycle-level properties of the translator, attached by bind.
module ctx_mmu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic [2:0] fc,
    input logic       wr,
    input logic       rsp_vld,
    input logic       fault,
    input logic       prom_sel,
    input logic       boot_on,
    input logic [2:0] uctx
);
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_vld);
    assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_vld);
    assert_iack_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && fc == 3'd7) |=> (!fault && !prom_sel));
    assert_boot_prom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && fc == 3'd6 && boot_on) |=> (prom_sel && !fault));
    assert_prom_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(prom_sel && fault));
    assert_user_ctx_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && fc != 3'd3) |=> $stable(uctx));
endmodule

bind ctx_mmu ctx_mmu_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .fc       (fc),
    .wr       (wr),
    .rsp_vld  (rsp_vld),
    .fault    (fault),
    .prom_sel (prom_sel),
    .boot_on  (boot_on),
    .uctx     (uctx)
);

// File: tb/ctx_mmu_tb_top.sv
module ctx_mmu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  fc = '0;
    logic        wr = 1'b0;
    logic [23:0] va = '0;
    logic [31:0] wdata = '0;
    logic        rsp_vld, fault, prom_sel;
    logic [30:0] pa;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ctx_mmu dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .fc(fc), .wr(wr), .va(va),
        .wdata(wdata), .rsp_vld(rsp_vld), .pa(pa), .fault(fault),
        .prom_sel(prom_sel), .rdata(rdata)
    );

    typedef struct packed {
        logic [2:0]  fc;
        logic        wr;
        logic [23:0] va;
        logic        efault;
        logic        eprom;
        logic [30:0] epa;
        logic [3:0]  rq;
    } vec_t;

    // uctx=5, sctx=2. Maps: ctx5/vseg3->seg21, ctx2/vseg1FF->seg7E, ctx5/vseg10->seg22.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, 24'h01A7FF, 1'b0, 1'b0, {20'hABCDE, 11'h7FF}, 4'd3},  // R3 user read
        '{3'd1, 1'b1, 24'h01A000, 1'b0, 1'b0, {20'hABCDE, 11'h000}, 4'd6},  // R6 write ok
        '{3'd2, 1'b0, 24'h01A923, 1'b0, 1'b0, {20'h00123, 11'h123}, 4'd6},  // R6 read-only read
        '{3'd1, 1'b1, 24'h01A923, 1'b1, 1'b0, {20'h00123, 11'h123}, 4'd6},  // R6 write faults
        '{3'd1, 1'b0, 24'h01B010, 1'b1, 1'b0, {20'h55555, 11'h010}, 4'd5},  // R5 user on sup page
        '{3'd5, 1'b0, 24'hFFF8AA, 1'b0, 1'b0, {20'hFFFFF, 11'h0AA}, 4'd3},  // R3 sup context
        '{3'd5, 1'b1, 24'hFFF8AA, 1'b0, 1'b0, {20'hFFFFF, 11'h0AA}, 4'd5},  // R5 sup allowed
        '{3'd1, 1'b0, 24'h080000, 1'b1, 1'b0, {20'h12345, 11'h000}, 4'd4},  // R4 invalid page
        '{3'd7, 1'b0, 24'h00FFF5, 1'b0, 1'b0, {7'd0, 24'h00FFF5},   4'd7},  // R7 iack
        '{3'd6, 1'b0, 24'hFFF8AA, 1'b0, 1'b0, {20'hFFFFF, 11'h0AA}, 4'd8}   // R8 boot off
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request cycle; outputs sampled at the following falling edge.
    task automatic access(input logic [2:0] f, input logic w, input logic [23:0] a,
                          input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; fc = f; wr = w; va = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    function automatic logic [23:0] cva(input logic [1:0] sel, input logic [11:0] idx);
        return {sel, 8'd0, idx, 2'b00};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rsp_vld", {31'd0, rsp_vld}, 32'd0);
        chk("R1 fault", {31'd0, fault}, 32'd0);
        chk("R1 prom_sel", {31'd0, prom_sel}, 32'd0);
        access(3'd3, 1'b0, cva(2'd2, 12'd0), 32'd0);
        chk("R1 boot/sctx readback", rdata, 32'h8);
        chk("R2 rsp after req", {31'd0, rsp_vld}, 32'd1);
        access(3'd3, 1'b0, cva(2'd3, 12'd0), 32'd0);
        chk("R1 uctx readback", rdata, 32'h0);
        @(negedge clk);
        chk("R2 idle no rsp", {31'd0, rsp_vld}, 32'd0);
        // R8 boot fetch goes to PROM
        access(3'd6, 1'b0, 24'h000400, 32'd0);
        chk("R8 prom_sel", {31'd0, prom_sel}, 32'd1);
        chk("R8 pa", {1'b0, pa}, 32'h400);
        chk("R8 no fault", {31'd0, fault}, 32'd0);
        // R9 load contexts, maps; leave boot mode
        access(3'd3, 1'b1, cva(2'd3, 12'd0), 32'd5);
        access(3'd3, 1'b1, cva(2'd2, 12'd0), 32'd2);
        access(3'd3, 1'b1, cva(2'd0, 12'hA03), 32'h21);
        access(3'd3, 1'b1, cva(2'd0, 12'h5FF), 32'h7E);
        access(3'd3, 1'b1, cva(2'd0, 12'hA10), 32'h22);
        access(3'd3, 1'b1, cva(2'd1, 12'h214), {9'd0, 3'b101, 20'hABCDE});
        access(3'd3, 1'b1, cva(2'd1, 12'h215), {9'd0, 3'b100, 20'h00123});
        access(3'd3, 1'b1, cva(2'd1, 12'h216), {9'd0, 3'b111, 20'h55555});
        access(3'd3, 1'b1, cva(2'd1, 12'h7EF), {9'd0, 3'b111, 20'hFFFFF});
        access(3'd3, 1'b1, cva(2'd1, 12'h220), {9'd0, 3'b000, 20'h12345});
        // R10 readback of map and registers
        access(3'd3, 1'b0, cva(2'd1, 12'h214), 32'd0);
        chk("R10 page entry", rdata, {9'd0, 3'b101, 20'hABCDE});
        access(3'd3, 1'b0, cva(2'd0, 12'h5FF), 32'd0);
        chk("R10 segment entry", rdata, 32'h7E);
        access(3'd3, 1'b0, cva(2'd2, 12'd0), 32'd0);
        chk("R10 sctx boot off", rdata, 32'h2);
        // R9 a non-control write to the user context selector is ignored
        access(3'd1, 1'b1, cva(2'd3, 12'd0), 32'd7);
        access(3'd3, 1'b0, cva(2'd3, 12'd0), 32'd0);
        chk("R9 uctx unchanged", rdata, 32'd5);
        // Vector table
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].fc, VECS[i].wr, VECS[i].va, 32'd0);
            chk($sformatf("R%0d vec%0d fault", VECS[i].rq, i), {31'd0, fault}, {31'd0, VECS[i].efault});
            chk($sformatf("R%0d vec%0d prom", VECS[i].rq, i), {31'd0, prom_sel}, {31'd0, VECS[i].eprom});
            if (!VECS[i].efault)
                chk($sformatf("R%0d vec%0d pa", VECS[i].rq, i), {1'b0, pa}, {1'b0, VECS[i].epa});
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule